// File: doc/BRIEF.md
# Drain-and-Branch Fetch Gate

This block steers the fetch stage of an out-of-order core so that the code controlled by a marked branch never overlaps in the pipeline with the code around it. Decode reports two kinds of marker instruction. An opening marker comes with the target that the branch selected. A closing marker carries no target and does not change control flow. Either marker stops fetch until every in-flight instruction, including the marker itself, has retired. After the drain after an opening marker, fetch restarts on the chosen path. After the drain after a closing marker, fetch restarts at the instruction that follows the marker. Inside the region the core still reorders instructions freely. Only the region's two edges are serialized.

The restart takes one cycle. In that cycle fetch is enabled and the next-PC select takes the address held by the block. A pipeline flush has priority over everything else: it ends any drain and restarts fetch at the flush target. A marker that decode presents while the block is not in its normal fetch state is held in decode and has no effect. The number of stalled cycles of the most recent completed drain of each kind is kept on two outputs, so that the cost of the isolation can be measured.

Top module: `dnb_fetch_gate`

## Requirements
- R1: After reset, fetch_en_o is 1, pc_sel_o is 0, decode_hold_o is 0 and both penalty outputs are 0.
- R2: An opening marker accepted while fetching (fetch_en_o=1, pc_sel_o=0) drives fetch_en_o to 0 from the next cycle.
- R3: A closing marker accepted while fetching drives fetch_en_o to 0 from the next cycle. If both markers come in the same cycle, the opening marker wins and its target is used.
- R4: A drain lasts until a cycle in which inflight_i is 0 and the marker has retired, where the retire pulse may come in that cycle or in any earlier cycle of the drain. In every earlier cycle fetch_en_o stays 0.
- R5: When a drain after an opening marker ends, there is exactly one cycle with fetch_en_o=1, pc_sel_o=1 and redirect_pc_o equal to the captured branch target. After that cycle, pc_sel_o returns to 0 (sequential).
- R6: When a drain after a closing marker ends, the redirect cycle carries redirect_pc_o = close_pc_i + INSTR_BYTES.
- R7: When a drain ends, the number of cycles with fetch_en_o=0 in that drain is placed on open_penalty_o or close_penalty_o, according to the marker kind. The count saturates at 2^PEN_W-1.
- R8: flush_i in any state gives, in the next cycle, fetch_en_o=1, pc_sel_o=1 and redirect_pc_o equal to flush_target_i. A drain that a flush ends leaves both penalty outputs unchanged.
- R9: A marker presented while the block is not fetching raises decode_hold_o in the same cycle. It starts no drain and leaves the redirect address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| open_mark_i | input | 1 | Opening marker decoded this cycle |
| open_target_i | input | PC_W | Path selected by the branch of the opening marker |
| close_mark_i | input | 1 | Closing marker decoded this cycle |
| close_pc_i | input | PC_W | Address of the closing marker |
| inflight_i | input | CNT_W | Number of instructions in flight in the core |
| mark_retired_i | input | 1 | The marker that started the drain retired this cycle |
| flush_i | input | 1 | Pipeline flush |
| flush_target_i | input | PC_W | Restart address of the flush |
| fetch_en_o | output | 1 | Fetch may proceed |
| pc_sel_o | output | 1 | 1 selects redirect_pc_o as the next PC, 0 selects sequential |
| redirect_pc_o | output | PC_W | Held restart address |
| decode_hold_o | output | 1 | Keep the presented marker in decode |
| open_penalty_o | output | PEN_W | Stall cycles of the last completed opening drain |
| close_penalty_o | output | PEN_W | Stall cycles of the last completed closing drain |

## Verification
A wrong state shows at once on fetch_en_o or pc_sel_o. A missed drain leaves fetch enabled in the cycle after the marker. A premature exit raises fetch while inflight_i is still nonzero. A stuck drain never produces the one-cycle redirect. A corrupted target or a lost retire flag shows only at the end of the drain, through the wrong redirect address or an extra stall cycle. A miscounting meter shows in the cycle after the redirect, through the penalty value.

// File: rtl/dnb_pkg.sv
package dnb_pkg;
   typedef enum logic [1:0] {
      GATE_RUN      = 2'd0,
      GATE_HOLD_IN  = 2'd1,
      GATE_HOLD_OUT = 2'd2,
      GATE_STEER    = 2'd3
   } gate_state_e;
endpackage

// File: rtl/dnb_gate_fsm.sv
module dnb_gate_fsm
   import dnb_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        open_mark,
   input  logic        close_mark,
   input  logic        flush,
   input  logic        drain_done,
   output gate_state_e state
);
   gate_state_e nxt;

   always_comb begin
      nxt = state;
      if (flush) begin
         nxt = GATE_STEER;
      end else begin
         case (state)
            GATE_RUN: begin
               if (open_mark)       nxt = GATE_HOLD_IN;
               else if (close_mark) nxt = GATE_HOLD_OUT;
            end
            GATE_HOLD_IN,
            GATE_HOLD_OUT: if (drain_done) nxt = GATE_STEER;
            default:       nxt = GATE_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= GATE_RUN;
      else        state <= nxt;
   end
endmodule

// File: rtl/dnb_target_latch.sv
module dnb_target_latch
   import dnb_pkg::*;
#(
   parameter int PC_W        = 32,
   parameter int INSTR_BYTES = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  gate_state_e     state,
   input  logic            open_mark,
   input  logic [PC_W-1:0] open_target,
   input  logic            close_mark,
   input  logic [PC_W-1:0] close_pc,
   input  logic            flush,
   input  logic [PC_W-1:0] flush_target,
   output logic [PC_W-1:0] target
);
   localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         target <= '0;
      end else if (flush) begin
         target <= flush_target;
      end else if (state == GATE_RUN) begin
         if (open_mark)       target <= open_target;
         else if (close_mark) target <= close_pc + STEP;
      end
   end
endmodule

// File: rtl/dnb_drain_meter.sv
module dnb_drain_meter #(
   parameter int PEN_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             done,
   input  logic             abort,
   output logic [PEN_W-1:0] penalty
);
   localparam logic [PEN_W-1:0] TOP = {PEN_W{1'b1}};

   logic [PEN_W-1:0] cnt;
   logic [PEN_W-1:0] cnt_inc;

   generate
      if (SATURATE) begin : g_sat
         assign cnt_inc = (cnt == TOP) ? TOP : cnt + 1'b1;
      end else begin : g_wrap
         assign cnt_inc = cnt + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         penalty <= '0;
      end else if (!active || abort) begin
         cnt <= '0;
      end else if (done) begin
         cnt     <= '0;
         penalty <= cnt_inc;
      end else begin
         cnt <= cnt_inc;
      end
   end
endmodule

// File: rtl/dnb_fetch_gate.sv
module dnb_fetch_gate
   import dnb_pkg::*;
#(
   parameter int PC_W        = 32,
   parameter int CNT_W       = 6,
   parameter int PEN_W       = 8,
   parameter int INSTR_BYTES = 4,
   parameter bit SATURATE    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_mark_i,
   input  logic [PC_W-1:0]  open_target_i,
   input  logic             close_mark_i,
   input  logic [PC_W-1:0]  close_pc_i,
   input  logic [CNT_W-1:0] inflight_i,
   input  logic             mark_retired_i,
   input  logic             flush_i,
   input  logic [PC_W-1:0]  flush_target_i,
   output logic             fetch_en_o,
   output logic             pc_sel_o,
   output logic [PC_W-1:0]  redirect_pc_o,
   output logic             decode_hold_o,
   output logic [PEN_W-1:0] open_penalty_o,
   output logic [PEN_W-1:0] close_penalty_o
);
   localparam int KINDS = 2;

   if (PC_W < 8) begin : g_chk_pc
      $error("PC_W too small");
   end
   if (CNT_W < 1) begin : g_chk_cnt
      $error("CNT_W must be positive");
   end
   if (PEN_W < 2) begin : g_chk_pen
      $error("PEN_W must be at least 2");
   end
   if (INSTR_BYTES <= 0 || (INSTR_BYTES & (INSTR_BYTES - 1)) != 0) begin : g_chk_step
      $error("INSTR_BYTES must be a power of two");
   end

   gate_state_e state;
   logic        draining;
   logic        retired_q;
   logic        drain_done;
   logic [PEN_W-1:0] pen [KINDS];

   assign draining   = (state == GATE_HOLD_IN) || (state == GATE_HOLD_OUT);
   assign drain_done = (inflight_i == '0) && (retired_q || mark_retired_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         retired_q <= 1'b0;
      else if (!draining) retired_q <= 1'b0;
      else if (mark_retired_i) retired_q <= 1'b1;
   end

   dnb_gate_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .open_mark  (open_mark_i),
      .close_mark (close_mark_i),
      .flush      (flush_i),
      .drain_done (drain_done),
      .state      (state)
   );

   dnb_target_latch #(.PC_W(PC_W), .INSTR_BYTES(INSTR_BYTES)) u_tgt (
      .clk          (clk),
      .rst_n        (rst_n),
      .state        (state),
      .open_mark    (open_mark_i),
      .open_target  (open_target_i),
      .close_mark   (close_mark_i),
      .close_pc     (close_pc_i),
      .flush        (flush_i),
      .flush_target (flush_target_i),
      .target       (redirect_pc_o)
   );

   for (genvar k = 0; k < KINDS; k++) begin : g_meter
      localparam gate_state_e KIND_ST = (k == 0) ? GATE_HOLD_IN : GATE_HOLD_OUT;
      dnb_drain_meter #(.PEN_W(PEN_W), .SATURATE(SATURATE)) u_meter (
         .clk     (clk),
         .rst_n   (rst_n),
         .active  (state == KIND_ST),
         .done    (drain_done),
         .abort   (flush_i),
         .penalty (pen[k])
      );
   end

   assign open_penalty_o  = pen[0];
   assign close_penalty_o = pen[1];
   assign fetch_en_o      = !draining;
   assign pc_sel_o        = (state == GATE_STEER);
   assign decode_hold_o   = (open_mark_i || close_mark_i) && (state != GATE_RUN);
endmodule

// File: rtl/dnb_fetch_gate_sva.sv
module dnb_fetch_gate_sva #(
   parameter int PC_W  = 32,
   parameter int CNT_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             open_mark_i,
   input logic             close_mark_i,
   input logic [CNT_W-1:0] inflight_i,
   input logic             flush_i,
   input logic [PC_W-1:0]  flush_target_i,
   input logic             fetch_en_o,
   input logic             pc_sel_o,
   input logic [PC_W-1:0]  redirect_pc_o
);
   // R2 and R3: a marker taken while fetching stops fetch
   assert_marker_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((open_mark_i || close_mark_i) && fetch_en_o && !pc_sel_o && !flush_i) |=> !fetch_en_o);

   // R4: no exit from a drain while instructions are still in flight
   assert_drain_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_en_o && inflight_i != '0 && !flush_i) |=> !fetch_en_o);

   // R3: fetch only stops because of a marker
   assert_stall_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fetch_en_o) |-> $past(open_mark_i || close_mark_i));

   // R5: every restart of fetch goes through the redirect select
   assert_restart_redirects_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fetch_en_o) |-> pc_sel_o);

   // R8: a flush during a drain restarts at the flush target
   assert_flush_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_i && !fetch_en_o) |=> (fetch_en_o && pc_sel_o && redirect_pc_o == $past(flush_target_i)));

   // R9: markers held during a drain leave the restart address alone
   assert_target_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_en_o && !flush_i) |=> $stable(redirect_pc_o));
endmodule

bind dnb_fetch_gate dnb_fetch_gate_sva #(.PC_W(PC_W), .CNT_W(CNT_W)) u_sva (
   .clk            (clk),
   .rst_n          (rst_n),
   .open_mark_i    (open_mark_i),
   .close_mark_i   (close_mark_i),
   .inflight_i     (inflight_i),
   .flush_i        (flush_i),
   .flush_target_i (flush_target_i),
   .fetch_en_o     (fetch_en_o),
   .pc_sel_o       (pc_sel_o),
   .redirect_pc_o  (redirect_pc_o)
);

// File: tb/dnb_fetch_gate_test.sv
module dnb_fetch_gate_test;
   localparam int PC_W = 32, CNT_W = 6, PEN_W = 8, NV = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic open_mark = 1'b0, close_mark = 1'b0, retired = 1'b0, flush = 1'b0;
   logic [PC_W-1:0] open_tgt = '0, close_pc = '0, flush_tgt = '0;
   logic [CNT_W-1:0] inflight = '0;
   logic fetch_en, pc_sel, hold;
   logic [PC_W-1:0] rpc;
   logic [PEN_W-1:0] pen_open, pen_close;

   int checks = 0, errors = 0;
   int exp_open = 0, exp_close = 0;

   // {kind(0 open,1 close), target, marker pc, cycle inflight reaches 0, cycle of retire}
   localparam logic [80:0] VEC [NV] = '{
      {1'b0, 32'h0000_1000, 32'h0000_0ffc, 8'd1, 8'd1},
      {1'b0, 32'h0000_2040, 32'h0000_0100, 8'd4, 8'd2},
      {1'b1, 32'h0000_0000, 32'h0000_3000, 8'd2, 8'd5},
      {1'b1, 32'h0000_0000, 32'h0000_7ffc, 8'd3, 8'd3},
      {1'b0, 32'h0000_abc0, 32'h0000_0010, 8'd6, 8'd1}
   };

   always #2.5 clk = ~clk;

   dnb_fetch_gate uut (
      .clk(clk), .rst_n(rst_n),
      .open_mark_i(open_mark), .open_target_i(open_tgt),
      .close_mark_i(close_mark), .close_pc_i(close_pc),
      .inflight_i(inflight), .mark_retired_i(retired),
      .flush_i(flush), .flush_target_i(flush_tgt),
      .fetch_en_o(fetch_en), .pc_sel_o(pc_sel), .redirect_pc_o(rpc),
      .decode_hold_o(hold), .open_penalty_o(pen_open), .close_penalty_o(pen_close)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Called at a negedge in the fetching state
   task automatic region(input bit kind, input logic [31:0] tgt, input logic [31:0] mpc,
                         input int z, input int r);
      int b = (z > r) ? z : r;
      logic [31:0] exp_pc = kind ? mpc + 32'd4 : tgt;
      int exp_pen = (b > 255) ? 255 : b;
      open_mark = !kind; close_mark = kind; open_tgt = tgt; close_pc = mpc; inflight = 6'd5;
      @(negedge clk);
      open_mark = 1'b0; close_mark = 1'b0;
      chk(kind ? "R3 stall on close" : "R2 stall on open", {31'd0, fetch_en}, 32'd0);
      for (int j = 1; j <= b; j++) begin
         inflight = (j >= z) ? 6'd0 : 6'd5;
         retired  = (j == r);
         @(negedge clk);
         if (j < b) chk("R4 drain held", {31'd0, fetch_en}, 32'd0);
      end
      retired = 1'b0; inflight = '0;
      chk("R5 redirect cycle", {30'd0, fetch_en, pc_sel}, 32'd3);
      chk(kind ? "R6 next sequential" : "R5 branch target", rpc, exp_pc);
      @(negedge clk);
      chk("R5 back to sequential", {30'd0, fetch_en, pc_sel}, 32'd2);
      if (kind) exp_close = exp_pen; else exp_open = exp_pen;
      chk("R7 open penalty", {24'd0, pen_open}, exp_open);
      chk("R7 close penalty", {24'd0, pen_close}, exp_close);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset outputs", {27'd0, fetch_en, pc_sel, hold, |pen_open, |pen_close}, 32'h10);

      for (int v = 0; v < NV; v++)
         region(VEC[v][80], VEC[v][79:48], VEC[v][47:16], int'(VEC[v][15:8]), int'(VEC[v][7:0]));

      // R3: both markers together, opening wins
      open_mark = 1'b1; close_mark = 1'b1; open_tgt = 32'h0000_5550; close_pc = 32'h0000_9000;
      inflight = 6'd2;
      @(negedge clk);
      open_mark = 1'b0; close_mark = 1'b0; inflight = '0; retired = 1'b1;
      @(negedge clk);
      retired = 1'b0;
      chk("R3 open wins target", rpc, 32'h0000_5550);
      exp_open = 1;
      @(negedge clk);
      chk("R3 open wins penalty", {24'd0, pen_open}, exp_open);

      // R9: marker inside a drain is held and ignored
      open_mark = 1'b1; open_tgt = 32'h0000_6000; inflight = 6'd3;
      @(negedge clk);
      open_tgt = 32'h0000_ee00; close_mark = 1'b1; close_pc = 32'h0000_1230;
      #1 chk("R9 hold raised", {31'd0, hold}, 32'd1);
      @(negedge clk);
      chk("R9 no effect while held", {31'd0, fetch_en}, 32'd0);
      open_mark = 1'b0; close_mark = 1'b0; inflight = '0; retired = 1'b1;
      @(negedge clk);
      retired = 1'b0;
      chk("R9 target unchanged", rpc, 32'h0000_6000);
      exp_open = 2;
      @(negedge clk);
      chk("R9 hold released", {31'd0, hold}, 32'd0);

      // R8: flush during a drain
      close_mark = 1'b1; close_pc = 32'h0000_4000; inflight = 6'd4;
      @(negedge clk);
      close_mark = 1'b0;
      @(negedge clk);
      flush = 1'b1; flush_tgt = 32'h0000_beef;
      @(negedge clk);
      flush = 1'b0; inflight = '0;
      chk("R8 flush restart", {30'd0, fetch_en, pc_sel}, 32'd3);
      chk("R8 flush target", rpc, 32'h0000_beef);
      @(negedge clk);
      chk("R8 penalties kept", {16'd0, pen_open, pen_close}, {16'd0, 8'(exp_open), 8'(exp_close)});

      // R8: flush while fetching
      flush = 1'b1; flush_tgt = 32'h0000_0a00;
      @(negedge clk);
      flush = 1'b0;
      chk("R8 flush in fetch", {30'd0, fetch_en, pc_sel}, 32'd3);
      chk("R8 flush in fetch target", rpc, 32'h0000_0a00);
      @(negedge clk);

      // R7: saturation on a long closing drain
      region(1'b1, 32'h0, 32'h0000_8000, 300, 300);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule